// File: doc/BRIEF.md
# Polled Character Display Port

This block is a character output port that sits on a 16-bit memory-mapped bus. It has two word addresses: a status word at 0xFE04 and a data word at 0xFE06. Software reads the status word until its ready flag is set, then stores a character into the data word. The port latches the low byte and offers it to a display sink through a one-cycle valid pulse. The sink answers with a done pulse after a delay that it chooses. No further character is accepted until that done pulse arrives.

The block decodes the bus address. It generates the data-register load enable and the status read select, and it drives the read data path. It also raises an interrupt request while the display is ready, if software has enabled interrupts in the status word. A store that arrives while the display is busy is dropped without any sign on the bus. Software therefore has to poll first, or wait for the interrupt.

Top module: `disp_port`

## Requirements
- R1: After reset the ready flag is 1, the interrupt enable is 0, irq is 0, char_valid is 0, and a read of 0xFE06 returns 0x0000.
- R2: A read at 0xFE04 asserts stat_sel in the same cycle and returns the ready flag in bit 15, the interrupt enable in bit 14, and zero in bits 13..0.
- R3: A store to 0xFE06 while ready is 1 asserts dat_load in that cycle, and the status word shows ready = 0 from the next cycle on.
- R4: The cycle after an accepted store, char_valid is high for exactly one cycle and char_byte equals bits 7..0 of the stored word. Characters reach the sink in the order they were accepted.
- R5: A store to 0xFE06 while ready is 0 is ignored. dat_load stays low, no char_valid follows, and the data readback keeps the previous character.
- R6: After an accepted store, ready stays 0 until the sink pulses char_done. It reads 1 in the cycle right after the cycle in which char_done was high.
- R7: A store to 0xFE04 sets the interrupt enable from bit 14 of the written word. Bit 15 and all other bits of that store do not change the ready flag.
- R8: irq is high exactly when both ready and the interrupt enable are 1. It falls in the cycle after an accepted store and rises again together with ready.
- R9: A read at 0xFE06 returns the last accepted character in bits 7..0 and zero in bits 15..8.
- R10: Reads and stores at any other address return 0x0000, assert neither dat_load nor stat_sel, and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Bus word address |
| bus_wr_en | input | 1 | Store strobe for the current cycle |
| bus_rd_en | input | 1 | Load strobe for the current cycle |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Load data (combinational) |
| dat_load | output | 1 | Data register load enable (accepted store) |
| stat_sel | output | 1 | Selects the status word onto the read path |
| char_valid | output | 1 | One-cycle character strobe to the sink |
| char_byte | output | 8 | Character offered to the sink |
| char_done | input | 1 | Sink completion pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the store that arrives while the display is busy. A port that lets that store through would overwrite the readback byte and send an extra strobe, and the scoreboard sees that as an unexpected character. It also pins down the exact cycle in which ready returns after done, using sink delays of one to six cycles. A design that sets ready early, or one cycle late, misses that cycle. Status stores with bit 15 cleared, and with every other bit set, expose a ready flag that the bus can write. Interrupt checks taken before, during and after a busy period catch an irq that ignores either ready or the enable.

// File: rtl/disp_pkg.sv
// Package: shared constants and types for the display output port.
// Assumes a single-word bus where one address is decoded per cycle.
package disp_pkg;
    localparam int unsigned BUS_W      = 16;
    localparam int unsigned CHR_W      = 8;
    localparam logic [BUS_W-1:0] STAT_ADDR_DEF = 16'hFE04;
    localparam logic [BUS_W-1:0] DATA_ADDR_DEF = 16'hFE06;
    localparam int unsigned RDY_POS_DEF = 15;
    localparam int unsigned IEN_POS_DEF = 14;

    // Decoded bus access for the current cycle
    typedef struct packed {
        logic stat_rd;
        logic stat_wr;
        logic data_rd;
        logic data_wr;
    } dec_t;
endpackage

// File: rtl/disp_decode.sv
// Module: address decoder for the two port registers.
// Assumes rd and wr strobes are qualified by the bus for one cycle each.
module disp_decode
    import disp_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output dec_t              dec
);
    logic hit_stat;
    logic hit_data;

    // Compare the address against both register locations
    always_comb begin
        hit_stat = (addr == STAT_ADDR);
        hit_data = (addr == DATA_ADDR);
    end

    // Qualify the hits with the access strobes
    always_comb begin
        dec.stat_rd = hit_stat & rd_en;
        dec.stat_wr = hit_stat & wr_en;
        dec.data_rd = hit_data & rd_en;
        dec.data_wr = hit_data & wr_en;
    end
endmodule

// File: rtl/disp_regs.sv
// Module: ready flag, interrupt enable and character holding register.
// Assumes the sink pulses done only while a character is outstanding;
// a done seen while ready is already 1 is ignored.
module disp_regs
    import disp_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned CHAR_W  = 8,
    parameter int unsigned IEN_POS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    output logic              accept,
    output logic              ready,
    output logic              ien,
    output logic [CHAR_W-1:0] chr
);
    logic              ready_q;
    logic              ien_q;
    logic [CHAR_W-1:0] chr_q;

    // A data store is taken only while the display is idle
    always_comb accept = dec.data_wr & ready_q;

    // Ready tracking: drop on accepted store, restore after sink done
    always_ff @(posedge clk) begin
        if (!rst_n)                 ready_q <= 1'b1;
        else if (accept)            ready_q <= 1'b0;
        else if (done && !ready_q)  ready_q <= 1'b1;
    end

    // Interrupt enable: loaded from its bit on any status store
    always_ff @(posedge clk) begin
        if (!rst_n)           ien_q <= 1'b0;
        else if (dec.stat_wr) ien_q <= wdata[IEN_POS];
    end

    // Character register: low byte of an accepted store
    always_ff @(posedge clk) begin
        if (!rst_n)      chr_q <= '0;
        else if (accept) chr_q <= wdata[CHAR_W-1:0];
    end

    assign ready = ready_q;
    assign ien   = ien_q;
    assign chr   = chr_q;
endmodule

// File: rtl/disp_emit.sv
// Module: sink handshake, one-cycle valid strobe after each accepted store.
// Assumes the character register is stable while the strobe is high.
module disp_emit #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CHAR_W-1:0] chr,
    output logic              valid,
    output logic [CHAR_W-1:0] byte_o
);
    logic valid_q;

    // Strobe for exactly the cycle following an accepted store
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= accept;
    end

    assign valid  = valid_q;
    assign byte_o = chr;
endmodule

// File: rtl/disp_port.sv
// Module: top of the memory-mapped character output port.
// Assumes one bus access per cycle; read data is combinational from state.
module disp_port
    import disp_pkg::*;
#(
    parameter int unsigned ADDR_W  = BUS_W,
    parameter int unsigned DATA_W  = BUS_W,
    parameter int unsigned CHAR_W  = CHR_W,
    parameter logic [ADDR_W-1:0] STAT_ADDR = STAT_ADDR_DEF,
    parameter logic [ADDR_W-1:0] DATA_ADDR = DATA_ADDR_DEF,
    parameter int unsigned RDY_POS = RDY_POS_DEF,
    parameter int unsigned IEN_POS = IEN_POS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dat_load,
    output logic              stat_sel,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_byte,
    input  logic              char_done,
    output logic              irq
);
    dec_t              dec_w;
    logic              accept_w;
    logic              ready_w;
    logic              ien_w;
    logic [CHAR_W-1:0] chr_w;

    disp_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
    ) dec_i (
        .addr(bus_addr), .wr_en(bus_wr_en), .rd_en(bus_rd_en), .dec(dec_w)
    );

    disp_regs #(
        .DATA_W(DATA_W), .CHAR_W(CHAR_W), .IEN_POS(IEN_POS)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .dec(dec_w), .wdata(bus_wdata),
        .done(char_done), .accept(accept_w), .ready(ready_w),
        .ien(ien_w), .chr(chr_w)
    );

    disp_emit #(.CHAR_W(CHAR_W)) emit_i (
        .clk(clk), .rst_n(rst_n), .accept(accept_w), .chr(chr_w),
        .valid(char_valid), .byte_o(char_byte)
    );

    // Read path: status word, zero-extended character, or zero
    always_comb begin
        bus_rdata = '0;
        if (dec_w.stat_rd) begin
            bus_rdata[RDY_POS] = ready_w;
            bus_rdata[IEN_POS] = ien_w;
        end else if (dec_w.data_rd) begin
            bus_rdata[CHAR_W-1:0] = chr_w;
        end
    end

    // Strobes and interrupt request toward the rest of the chip
    always_comb begin
        dat_load = accept_w;
        stat_sel = dec_w.stat_rd;
        irq      = ready_w & ien_w;
    end
endmodule

// File: rtl/disp_port_chk.sv
// Module: protocol checker bound to the display port top.
// Assumes it observes the internal ready and enable state through the bind.
module disp_port_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic              dat_load,
    input logic              stat_sel,
    input logic              char_valid,
    input logic              char_done,
    input logic              irq,
    input logic              rdy,
    input logic              ien
);
    assert_sel_on_status_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == STAT_ADDR) |-> stat_sel);
    assert_sel_only_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_sel |-> (bus_rd_en && bus_addr == STAT_ADDR));
    assert_load_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_load |=> !rdy);
    assert_valid_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dat_load |=> char_valid);
    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);
    assert_busy_store_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == DATA_ADDR && !rdy) |-> !dat_load);
    assert_done_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !rdy) |=> rdy);
    assert_ready_held_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !char_done) |=> !rdy);
    assert_status_store_keeps_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == STAT_ADDR && !char_done) |=> $stable(rdy));
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);
    assert_irq_quiet_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> !irq);
endmodule

bind disp_port disp_port_chk #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .dat_load(dat_load), .stat_sel(stat_sel),
    .char_valid(char_valid), .char_done(char_done), .irq(irq),
    .rdy(ready_w), .ien(ien_w)
);

// File: tb/disp_port_tb_top.sv
// Bench: scoreboard of characters, driver tasks on the bus, and a sink model.
module disp_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] STAT = 16'hFE04;
    localparam logic [15:0] DATA = 16'hFE06;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dat_load, stat_sel, char_valid, irq;
    logic [7:0]  char_byte;
    logic        char_done = 1'b0;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int done_cyc = -100;
    int sink_delay = 1;
    logic [7:0] exp_q[$];
    logic m_ready = 1'b1;

    disp_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dat_load(dat_load), .stat_sel(stat_sel), .char_valid(char_valid),
        .char_byte(char_byte), .char_done(char_done), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Store: data stores are accepted only while the bench model says ready
    task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input string req);
        logic exp_ld;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1; bus_rd_en = 1'b0;
        exp_ld = (a == DATA) && m_ready;
        #2;
        chk(dat_load == exp_ld, req, {15'b0, dat_load}, {15'b0, exp_ld});
        if (exp_ld) begin
            exp_q.push_back(d[7:0]);
            m_ready = 1'b0;
            done_cyc = -100;
        end
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_wr_en = 1'b0; bus_rd_en = 1'b1;
        #2;
        chk(bus_rdata == exp, req, bus_rdata, exp);
        chk(stat_sel == (a == STAT), {req, " sel"}, {15'b0, stat_sel}, {15'b0, a == STAT});
    endtask

    // Poll status every cycle; ready must show exactly one cycle after done (R6)
    task automatic wait_ready();
        bus_addr = STAT; bus_wr_en = 1'b0; bus_rd_en = 1'b1;
        for (int i = 0; i < 100; i++) begin
            #2;
            if (bus_rdata[15]) break;
            @(negedge clk);
        end
        chk(bus_rdata[15] && cyc == done_cyc + 1, "R6", cyc[15:0], done_cyc[15:0] + 16'd1);
        m_ready = 1'b1;
    endtask

    // Sink model: answer every strobe with done after sink_delay cycles
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (char_valid) begin
                repeat (sink_delay - 1) @(negedge clk);
                #1;
                char_done = 1'b1;
                done_cyc = cyc;
                @(negedge clk);
                char_done = 1'b0;
            end
        end
    end

    // Monitor: pop and compare each strobed character, check pulse width
    initial begin
        logic prev_v;
        logic [7:0] e;
        prev_v = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (char_valid) begin
                chk(!prev_v, "R4 pulse", {15'b0, prev_v}, 16'h0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected strobe", {8'h00, char_byte}, 16'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(char_byte == e, "R4", {8'h00, char_byte}, {8'h00, e});
                end
            end
            prev_v = char_valid;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "watchdog", 16'h0, 16'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk(irq == 1'b0, "R1 irq", {15'b0, irq}, 16'h0);
        chk(char_valid == 1'b0, "R1 valid", {15'b0, char_valid}, 16'h0);
        bus_read(STAT, 16'h8000, "R1 status");
        bus_read(DATA, 16'h0000, "R1 data");
        // R7 R8 enable on, then bit 15 write and other bits ignored
        bus_write(STAT, 16'h4000, "R7");
        bus_read(STAT, 16'hC000, "R7 R2");
        chk(irq == 1'b1, "R8 enabled idle", {15'b0, irq}, 16'h1);
        bus_write(STAT, 16'h0000, "R7");
        bus_read(STAT, 16'h8000, "R7 bit15");
        chk(irq == 1'b0, "R8 disabled", {15'b0, irq}, 16'h0);
        bus_write(STAT, 16'hBFFF, "R7");
        bus_read(STAT, 16'h8000, "R7 other bits");
        // R3 R5 R9: accept one, drop one while busy
        sink_delay = 5;
        bus_write(DATA, 16'h5A41, "R3 load");
        bus_read(STAT, 16'h0000, "R3 busy");
        bus_write(DATA, 16'h0042, "R5 load");
        bus_read(DATA, 16'h0041, "R9 R5 readback");
        @(negedge clk);
        wait_ready();
        bus_read(STAT, 16'h8000, "R6 idle");
        // R8 irq across a busy period
        bus_write(STAT, 16'h4000, "R7");
        #1 chk(irq == 1'b1, "R8 before", {15'b0, irq}, 16'h1);
        sink_delay = 3;
        bus_write(DATA, 16'h0063, "R3 load");
        #1 chk(irq == 1'b0, "R8 busy", {15'b0, irq}, 16'h0);
        wait_ready();
        #1 chk(irq == 1'b1, "R8 after", {15'b0, irq}, 16'h1);
        bus_write(STAT, 16'h0000, "R7");
        // R10 foreign address
        bus_write(16'hFE00, 16'hFFFF, "R10 load");
        bus_write(16'hFE05, 16'h4000, "R10 load");
        bus_read(16'hFE00, 16'h0000, "R10 read");
        bus_read(16'hFE07, 16'h0000, "R10 read");
        bus_read(STAT, 16'h8000, "R10 state");
        bus_read(DATA, 16'h0063, "R10 R9 data");
        // Burst with varying sink delays
        for (int k = 0; k < 4; k++) begin
            sink_delay = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 6 : 1;
            bus_write(DATA, 16'hFF70 + 16'(k), "R3 load");
            wait_ready();
            bus_read(DATA, 16'h0070 + 16'(k), "R9 burst");
        end
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all emitted", 16'(exp_q.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule